// File: doc/BRIEF.md
# OFDM Input Ready Pacing Generator

This block sits at the input of an OFDM modulator. It paces the delivery of active subcarrier samples with a `ready` handshake, one symbol period at a time. Each period opens when the first valid beat of a symbol is accepted. On that beat the block captures the symbol's settings: transform size, prefix length, the guard counts at the two band edges and the DC-null flag. From these it works out how long `ready` stays high (one cycle per active subcarrier). It then works out how long `ready` stays low so that the whole period covers the symbol plus its cyclic prefix.

The settings come either from module parameters (fixed mode, `RUNTIME = 0`) or from input ports (runtime mode, `RUNTIME = 1`). In runtime mode the low time is measured against a maximum transform size supplied on a port, because the datapath downstream always runs at that size. The captured settings are presented on registered outputs and stay unchanged until the next symbol opens. Symbol assembly and the transform are handled elsewhere.

Top module: `ofdm_ready_pacer`

## Requirements
- R1: From the capture beat onward, `readyOut` is high for exactly H = fftLen − leftGuard − rightGuard − dcNull cycles. The capture cycle is the first of them, and dcNull counts as 0 or 1.
- R2: In fixed mode the low time that follows is fftLen + cpLen − H cycles. With the defaults (64, 16, 6, 5, DC null on) that gives 52 cycles high and 28 cycles low, and the captured outputs read the parameter values whatever the port inputs carry.
- R3: In runtime mode the low time is maxFftLen + cpLen − H cycles, using the maximum size present on the capture beat.
- R4: Settings are captured only on the first valid beat of a symbol while `readyOut` is high. Later valid beats in the same high window leave the outputs and the high time unchanged.
- R5: In runtime mode `readyOut` rises only when `cfgPresentIn` was high at the preceding clock edge. This applies after reset and at the end of each low window. While `cfgPresentIn` stays low, `readyOut` stays low.
- R6: A valid beat while `readyOut` is low has no effect. It changes neither the captured outputs nor the length of the low window.
- R7: At the end of the low window `readyOut` returns high and stays high until the next valid beat opens a symbol. When the low time is zero, `readyOut` stays high continuously across back-to-back symbols.
- R8: A synchronous `rst` aborts the current symbol. In the following cycle `readyOut` is 0 and all captured outputs are 0.
- R9: Captured settings must be legal: fftLen is a power of two, at least 8 and not above maxFftLen. maxFftLen is a power of two not above `MAX_FFT_LEN`. cpLen is at most fftLen. Each guard count is below fftLen/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgPresentIn | input | 1 | Runtime settings are present on the inputs |
| validIn | input | 1 | Input sample valid |
| fftLenIn | input | LEN_W | Transform size for the next symbol |
| cpLenIn | input | LEN_W | Cyclic prefix length |
| maxFftLenIn | input | LEN_W | Maximum transform size (runtime mode) |
| leftGuardIn | input | GUARD_W | Guard subcarriers at the low band edge |
| rightGuardIn | input | GUARD_W | Guard subcarriers at the high band edge |
| dcNullIn | input | 1 | Null the DC subcarrier |
| readyOut | output | 1 | Block accepts a sample in this cycle |
| fftLenOut | output | LEN_W | Captured transform size |
| cpLenOut | output | LEN_W | Captured prefix length |
| leftGuardOut | output | GUARD_W | Captured low-edge guard count |
| rightGuardOut | output | GUARD_W | Captured high-edge guard count |
| dcNullOut | output | 1 | Captured DC-null flag |

## Verification
The embedded properties check on every cycle that each high window matches the length derived from the captured outputs. They also check that each low window lasts at least its derived length, that the outputs never move without an accepted beat, that reset clears everything, that `readyOut` never rises without configuration present, and that captured settings are legal. Other behaviour only the directed scenarios can show:
- the exact low-window length when configuration stays present;
- a change of inputs in mid-symbol taking effect only at the next symbol;
- the idle-high wait for a late first beat;
- the zero-low back-to-back case;
- the single-subcarrier boundary;
- the fixed-mode instance ignoring its ports.

// File: rtl/ofdm_ready_pacer_pkg.sv
package ofdm_ready_pacer_pkg;

  typedef enum logic [1:0] {
    PHASE_IDLE  = 2'd0,
    PHASE_ARMED = 2'd1,
    PHASE_HIGH  = 2'd2,
    PHASE_LOW   = 2'd3
  } pacer_phase_t;

  // control -> datapath
  typedef struct packed {
    logic capture;
    logic loadLow;
    logic dec;
  } pacer_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic highIsOne;
    logic lowZeroNew;
    logic lowZeroHeld;
    logic cntLast;
  } pacer_status_t;

endpackage

// File: rtl/ofdm_ready_pacer_dp.sv
module ofdm_ready_pacer_dp
  import ofdm_ready_pacer_pkg::*;
#(
  parameter int RUNTIME         = 1,
  parameter int LEN_W           = 8,
  parameter int GUARD_W         = 6,
  parameter int CNT_W           = 9,
  parameter int FIX_FFT_LEN     = 64,
  parameter int FIX_CP_LEN      = 16,
  parameter int FIX_LEFT_GUARD  = 6,
  parameter int FIX_RIGHT_GUARD = 5,
  parameter int FIX_DC_NULL     = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  pacer_strobe_t      strobe,
  output pacer_status_t      status,
  input  logic [LEN_W-1:0]   fftLenIn,
  input  logic [LEN_W-1:0]   cpLenIn,
  input  logic [LEN_W-1:0]   maxFftLenIn,
  input  logic [GUARD_W-1:0] leftGuardIn,
  input  logic [GUARD_W-1:0] rightGuardIn,
  input  logic               dcNullIn,
  output logic [LEN_W-1:0]   fftLenOut,
  output logic [LEN_W-1:0]   cpLenOut,
  output logic [GUARD_W-1:0] leftGuardOut,
  output logic [GUARD_W-1:0] rightGuardOut,
  output logic               dcNullOut
);

  logic [LEN_W-1:0]   srcFft, srcCp, srcBase;
  logic [GUARD_W-1:0] srcLeft, srcRight;
  logic               srcDc;

  // pick where the per-symbol settings come from
  if (RUNTIME != 0) begin : g_portSrc
    assign srcFft   = fftLenIn;
    assign srcCp    = cpLenIn;
    assign srcBase  = maxFftLenIn;
    assign srcLeft  = leftGuardIn;
    assign srcRight = rightGuardIn;
    assign srcDc    = dcNullIn;
  end else begin : g_constSrc
    assign srcFft   = LEN_W'(FIX_FFT_LEN);
    assign srcCp    = LEN_W'(FIX_CP_LEN);
    assign srcBase  = LEN_W'(FIX_FFT_LEN);
    assign srcLeft  = GUARD_W'(FIX_LEFT_GUARD);
    assign srcRight = GUARD_W'(FIX_RIGHT_GUARD);
    assign srcDc    = FIX_DC_NULL != 0;
  end

  logic [CNT_W-1:0] guardSum, highLen, lowLen;
  logic [CNT_W-1:0] lowLenQ, cntQ;

  assign guardSum = CNT_W'(srcLeft) + CNT_W'(srcRight) + CNT_W'(srcDc);
  assign highLen  = CNT_W'(srcFft) - guardSum;
  assign lowLen   = CNT_W'(srcBase) + CNT_W'(srcCp) - highLen;

  assign status.highIsOne   = (highLen == CNT_W'(1));
  assign status.lowZeroNew  = (lowLen == '0);
  assign status.lowZeroHeld = (lowLenQ == '0);
  assign status.cntLast     = (cntQ == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fftLenOut     <= '0;
      cpLenOut      <= '0;
      leftGuardOut  <= '0;
      rightGuardOut <= '0;
      dcNullOut     <= 1'b0;
      lowLenQ       <= '0;
    end else if (strobe.capture) begin
      fftLenOut     <= srcFft;
      cpLenOut      <= srcCp;
      leftGuardOut  <= srcLeft;
      rightGuardOut <= srcRight;
      dcNullOut     <= srcDc;
      lowLenQ       <= lowLen;
    end
  end

  // one down counter serves both windows
  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ <= '0;
    end else if (strobe.loadLow) begin
      cntQ <= strobe.capture ? lowLen : lowLenQ;
    end else if (strobe.capture) begin
      cntQ <= highLen - CNT_W'(1);
    end else if (strobe.dec) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  // R1 R2 R3: a window never counts below zero
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.dec && !strobe.loadLow) |-> (cntQ != '0));

endmodule

// File: rtl/ofdm_ready_pacer_ctrl.sv
module ofdm_ready_pacer_ctrl
  import ofdm_ready_pacer_pkg::*;
#(
  parameter int RUNTIME = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          validIn,
  input  logic          cfgPresentIn,
  input  pacer_status_t status,
  output pacer_strobe_t strobe,
  output logic          readyOut
);

  pacer_phase_t phaseQ, phaseD;
  logic cfgOk;
  pacer_phase_t restPhase;

  assign cfgOk     = (RUNTIME == 0) || cfgPresentIn;
  assign restPhase = cfgOk ? PHASE_ARMED : PHASE_IDLE;

  always_comb begin
    strobe = '0;
    phaseD = phaseQ;
    case (phaseQ)
      PHASE_IDLE: begin
        if (cfgOk) phaseD = PHASE_ARMED;
      end
      PHASE_ARMED: begin
        if (validIn) begin
          strobe.capture = 1'b1;
          if (!status.highIsOne) begin
            phaseD = PHASE_HIGH;
          end else if (status.lowZeroNew) begin
            phaseD = restPhase;
          end else begin
            strobe.loadLow = 1'b1;
            phaseD = PHASE_LOW;
          end
        end
      end
      PHASE_HIGH: begin
        strobe.dec = 1'b1;
        if (status.cntLast) begin
          if (status.lowZeroHeld) begin
            phaseD = restPhase;
          end else begin
            strobe.loadLow = 1'b1;
            phaseD = PHASE_LOW;
          end
        end
      end
      default: begin
        strobe.dec = 1'b1;
        if (status.cntLast) phaseD = restPhase;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phaseQ <= PHASE_IDLE;
    else     phaseQ <= phaseD;
  end

  assign readyOut = (phaseQ == PHASE_ARMED) || (phaseQ == PHASE_HIGH);

  // R5
  cfg_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(readyOut) |-> ((RUNTIME == 0) || $past(cfgPresentIn)));

endmodule

// File: rtl/ofdm_ready_pacer.sv
module ofdm_ready_pacer
  import ofdm_ready_pacer_pkg::*;
#(
  parameter int MAX_FFT_LEN     = 128,
  parameter int RUNTIME         = 1,
  parameter int FIX_FFT_LEN     = 64,
  parameter int FIX_CP_LEN      = 16,
  parameter int FIX_LEFT_GUARD  = 6,
  parameter int FIX_RIGHT_GUARD = 5,
  parameter int FIX_DC_NULL     = 1,
  localparam int LEN_W   = $clog2(MAX_FFT_LEN) + 1,
  localparam int GUARD_W = $clog2(MAX_FFT_LEN) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgPresentIn,
  input  logic               validIn,
  input  logic [LEN_W-1:0]   fftLenIn,
  input  logic [LEN_W-1:0]   cpLenIn,
  input  logic [LEN_W-1:0]   maxFftLenIn,
  input  logic [GUARD_W-1:0] leftGuardIn,
  input  logic [GUARD_W-1:0] rightGuardIn,
  input  logic               dcNullIn,
  output logic               readyOut,
  output logic [LEN_W-1:0]   fftLenOut,
  output logic [LEN_W-1:0]   cpLenOut,
  output logic [GUARD_W-1:0] leftGuardOut,
  output logic [GUARD_W-1:0] rightGuardOut,
  output logic               dcNullOut
);

  localparam int CNT_W = LEN_W + 1;

  pacer_strobe_t strobe;
  pacer_status_t status;

  ofdm_ready_pacer_ctrl #(.RUNTIME(RUNTIME)) i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .validIn      (validIn),
    .cfgPresentIn (cfgPresentIn),
    .status       (status),
    .strobe       (strobe),
    .readyOut     (readyOut)
  );

  ofdm_ready_pacer_dp #(
    .RUNTIME         (RUNTIME),
    .LEN_W           (LEN_W),
    .GUARD_W         (GUARD_W),
    .CNT_W           (CNT_W),
    .FIX_FFT_LEN     (FIX_FFT_LEN),
    .FIX_CP_LEN      (FIX_CP_LEN),
    .FIX_LEFT_GUARD  (FIX_LEFT_GUARD),
    .FIX_RIGHT_GUARD (FIX_RIGHT_GUARD),
    .FIX_DC_NULL     (FIX_DC_NULL)
  ) i_dp (
    .clk           (clk),
    .rst           (rst),
    .strobe        (strobe),
    .status        (status),
    .fftLenIn      (fftLenIn),
    .cpLenIn       (cpLenIn),
    .maxFftLenIn   (maxFftLenIn),
    .leftGuardIn   (leftGuardIn),
    .rightGuardIn  (rightGuardIn),
    .dcNullIn      (dcNullIn),
    .fftLenOut     (fftLenOut),
    .cpLenOut      (cpLenOut),
    .leftGuardOut  (leftGuardOut),
    .rightGuardOut (rightGuardOut),
    .dcNullOut     (dcNullOut)
  );

  // ---- window-length tracking for the properties below ----
  localparam logic [1:0] TRK_NONE = 2'd0, TRK_HIGH = 2'd1, TRK_LOW = 2'd2;
  logic [1:0]       trkQ;
  logic [CNT_W:0]   runCnt;
  logic [LEN_W-1:0] maxQ;
  logic [CNT_W-1:0] expHigh, expLow;

  assign expHigh = CNT_W'(fftLenOut) - CNT_W'(leftGuardOut)
                 - CNT_W'(rightGuardOut) - CNT_W'(dcNullOut);
  assign expLow  = CNT_W'((RUNTIME != 0) ? maxQ : fftLenOut)
                 + CNT_W'(cpLenOut) - expHigh;

  always_ff @(posedge clk) begin
    if (rst) begin
      trkQ   <= TRK_NONE;
      runCnt <= '0;
      maxQ   <= '0;
    end else if (strobe.capture) begin
      trkQ   <= TRK_HIGH;
      runCnt <= (CNT_W+1)'(1);
      maxQ   <= maxFftLenIn;
    end else if (trkQ == TRK_HIGH) begin
      if (readyOut) begin
        runCnt <= runCnt + (CNT_W+1)'(1);
      end else begin
        trkQ   <= TRK_LOW;
        runCnt <= (CNT_W+1)'(1);
      end
    end else if (trkQ == TRK_LOW) begin
      if (readyOut) trkQ <= TRK_NONE;
      else          runCnt <= runCnt + (CNT_W+1)'(1);
    end
  end

  // R1
  high_len_chk: assert property (@(posedge clk) disable iff (rst)
    (trkQ == TRK_HIGH && (!readyOut || strobe.capture)) |-> (runCnt == (CNT_W+1)'(expHigh)));

  // R2 R3
  low_len_chk: assert property (@(posedge clk) disable iff (rst)
    (trkQ == TRK_LOW && readyOut) |-> (runCnt >= (CNT_W+1)'(expLow)));

  // R4 R6
  param_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(readyOut && validIn) |=> $stable({fftLenOut, cpLenOut, leftGuardOut, rightGuardOut, dcNullOut}));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!readyOut && fftLenOut == '0 && cpLenOut == '0 && leftGuardOut == '0
             && rightGuardOut == '0 && !dcNullOut));

  if (RUNTIME != 0) begin : g_legalChk
    // R9
    cfg_legal_chk: assert property (@(posedge clk) disable iff (rst)
      strobe.capture |-> ($countones(fftLenIn) == 1 && fftLenIn >= LEN_W'(8)
        && fftLenIn <= maxFftLenIn && $countones(maxFftLenIn) == 1
        && maxFftLenIn <= LEN_W'(MAX_FFT_LEN) && cpLenIn <= fftLenIn
        && LEN_W'(leftGuardIn) < (fftLenIn >> 1)
        && LEN_W'(rightGuardIn) < (fftLenIn >> 1)));
  end

endmodule

// File: tb/test_ofdm_ready_pacer.sv
module test_ofdm_ready_pacer;

  localparam int MAXF = 128;
  localparam int LW   = $clog2(MAXF) + 1;
  localparam int GW   = $clog2(MAXF) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgPresent = 1'b0;
  logic valid = 1'b0;
  logic [LW-1:0] fftLen = '0, cpLen = '0, maxLen = '0;
  logic [GW-1:0] lGuard = '0, rGuard = '0;
  logic dcNull = 1'b0;

  logic readyRt, readyFix;
  logic [LW-1:0] fftRt, cpRt, fftFix, cpFix;
  logic [GW-1:0] lgRt, rgRt, lgFix, rgFix;
  logic dcRt, dcFix;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  ofdm_ready_pacer #(.MAX_FFT_LEN(MAXF), .RUNTIME(1)) i_ofdm_ready_pacer (
    .clk(clk), .rst(rst), .cfgPresentIn(cfgPresent), .validIn(valid),
    .fftLenIn(fftLen), .cpLenIn(cpLen), .maxFftLenIn(maxLen),
    .leftGuardIn(lGuard), .rightGuardIn(rGuard), .dcNullIn(dcNull),
    .readyOut(readyRt), .fftLenOut(fftRt), .cpLenOut(cpRt),
    .leftGuardOut(lgRt), .rightGuardOut(rgRt), .dcNullOut(dcRt));

  ofdm_ready_pacer #(.MAX_FFT_LEN(MAXF), .RUNTIME(0)) i_ofdm_ready_pacerFixed (
    .clk(clk), .rst(rst), .cfgPresentIn(cfgPresent), .validIn(valid),
    .fftLenIn(fftLen), .cpLenIn(cpLen), .maxFftLenIn(maxLen),
    .leftGuardIn(lGuard), .rightGuardIn(rGuard), .dcNullIn(dcNull),
    .readyOut(readyFix), .fftLenOut(fftFix), .cpLenOut(cpFix),
    .leftGuardOut(lgFix), .rightGuardOut(rgFix), .dcNullOut(dcFix));

  function automatic int packCfg(int f, int c, int l, int r, int d);
    return (f << 21) | (c << 13) | (l << 7) | (r << 1) | d;
  endfunction

  function automatic int outRt();
    return packCfg(int'(fftRt), int'(cpRt), int'(lgRt), int'(rgRt), int'(dcRt));
  endfunction

  function automatic int outFix();
    return packCfg(int'(fftFix), int'(cpFix), int'(lgFix), int'(rgFix), int'(dcFix));
  endfunction

  function automatic logic rdy(bit useFix);
    return useFix ? readyFix : readyRt;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setCfg(int f, int c, int l, int r, int d, int m);
    fftLen = LW'(f); cpLen = LW'(c); lGuard = GW'(l); rGuard = GW'(r);
    dcNull = d[0]; maxLen = LW'(m);
  endtask

  task automatic waitLevel(bit useFix, logic lvl);
    int n = 0;
    while (rdy(useFix) !== lvl && n < 3000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // sync to a fresh symbol and count its high and low windows
  task automatic measure(bit useFix, output int hi, output int lo);
    waitLevel(useFix, 1'b0);
    waitLevel(useFix, 1'b1);
    hi = 0;
    while (rdy(useFix) === 1'b1 && hi < 3000) begin hi++; @(negedge clk); end
    lo = 0;
    while (rdy(useFix) === 1'b0 && lo < 3000) begin lo++; @(negedge clk); end
  endtask

  task automatic testReset();
    repeat (5) @(negedge clk);
    check(readyRt === 1'b0, "R8", "ready during reset", int'(readyRt), 0);
    check(outRt() == 0, "R8", "outputs during reset", outRt(), 0);
    rst = 1'b0;
    setCfg(64, 16, 6, 5, 1, 64);
    valid = 1'b1;
    begin
      int highSeen = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (readyRt !== 1'b0) highSeen++;
      end
      check(highSeen == 0, "R5", "ready without config", highSeen, 0);
      check(outRt() == 0, "R6", "outputs after ignored beats", outRt(), 0);
    end
  endtask

  task automatic testDefaults();
    int hi, lo;
    cfgPresent = 1'b1;
    setCfg(64, 16, 6, 5, 1, 64);
    measure(0, hi, lo);
    check(hi == 52, "R1", "default high window", hi, 52);
    check(lo == 28, "R3", "default low window (max=fft)", lo, 28);
    check(outRt() == packCfg(64, 16, 6, 5, 1), "R4", "captured defaults",
          outRt(), packCfg(64, 16, 6, 5, 1));
  endtask

  task automatic testLargerMax();
    int hi, lo;
    setCfg(64, 16, 6, 5, 1, 128);
    measure(0, hi, lo);
    check(hi == 52, "R1", "high window with max 128", hi, 52);
    check(lo == 92, "R3", "low window with max 128", lo, 92);
  endtask

  task automatic testSingleCarrier();
    int hi, lo;
    setCfg(8, 0, 3, 3, 1, 128);
    measure(0, hi, lo);
    check(hi == 1, "R1", "single active subcarrier high", hi, 1);
    check(lo == 127, "R3", "single active subcarrier low", lo, 127);
    check(outRt() == packCfg(8, 0, 3, 3, 1), "R4", "captured small config",
          outRt(), packCfg(8, 0, 3, 3, 1));
  endtask

  task automatic testZeroLow();
    int lows = 0;
    setCfg(8, 0, 0, 0, 0, 8);
    waitLevel(0, 1'b1);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      if (readyRt !== 1'b1) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R7", "ready stays high with zero low time", lows, 0);
    check(outRt() == packCfg(8, 0, 0, 0, 0), "R4", "captured zero-low config",
          outRt(), packCfg(8, 0, 0, 0, 0));
  endtask

  task automatic testMidSymbolChange();
    int hi, lo, bad;
    int cfgA = packCfg(64, 16, 6, 5, 1);
    setCfg(64, 16, 6, 5, 1, 64);
    waitLevel(0, 1'b0);
    waitLevel(0, 1'b1);
    hi = 1;
    bad = 0;
    @(negedge clk);
    setCfg(32, 8, 2, 2, 0, 64);
    while (readyRt === 1'b1 && hi < 3000) begin
      if (outRt() != cfgA) bad++;
      hi++;
      @(negedge clk);
    end
    lo = 0;
    while (readyRt === 1'b0 && lo < 3000) begin
      if (outRt() != cfgA) bad++;
      lo++;
      @(negedge clk);
    end
    check(hi == 52, "R4", "high window after mid-symbol change", hi, 52);
    check(bad == 0, "R4", "outputs moved within symbol", bad, 0);
    measure(0, hi, lo);
    check(hi == 28 && lo == 44, "R1", "next symbol windows (hi*1000+lo)",
          hi * 1000 + lo, 28044);
    check(outRt() == packCfg(32, 8, 2, 2, 0), "R4", "next symbol capture",
          outRt(), packCfg(32, 8, 2, 2, 0));
  endtask

  task automatic testArmedWait();
    int hi, lo, bad;
    int cfgC = packCfg(64, 16, 6, 5, 1);
    int cfgD = packCfg(16, 4, 1, 1, 1);
    setCfg(64, 16, 6, 5, 1, 64);
    measure(0, hi, lo);
    valid = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (readyRt !== 1'b1 || outRt() != cfgC) bad++;
    end
    check(bad == 0, "R7", "ready held high waiting for first beat", bad, 0);
    setCfg(16, 4, 1, 1, 1, 64);
    valid = 1'b1;
    hi = 0;
    while (readyRt === 1'b1 && hi < 3000) begin hi++; @(negedge clk); end
    check(hi == 13, "R1", "high window after late first beat", hi, 13);
    setCfg(32, 0, 0, 0, 0, 64);
    lo = 0;
    bad = 0;
    while (readyRt === 1'b0 && lo < 3000) begin
      if (outRt() != cfgD) bad++;
      lo++;
      @(negedge clk);
    end
    check(lo == 55, "R6", "low window with beats while not ready", lo, 55);
    check(bad == 0, "R6", "outputs moved while not ready", bad, 0);
  endtask

  task automatic testConfigGate();
    int highs = 0;
    cfgPresent = 1'b0;
    waitLevel(0, 1'b0);
    for (int i = 0; i < 45; i++) begin
      if (readyRt !== 1'b0) highs++;
      @(negedge clk);
    end
    check(highs == 0, "R5", "ready stays low without config", highs, 0);
    cfgPresent = 1'b1;
    @(negedge clk);
    check(readyRt === 1'b1, "R5", "ready returns after config", int'(readyRt), 1);
  endtask

  task automatic testResetMidSymbol();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(readyRt === 1'b0, "R8", "ready after mid-symbol reset", int'(readyRt), 0);
    check(outRt() == 0, "R8", "outputs after mid-symbol reset", outRt(), 0);
    rst = 1'b0;
    @(negedge clk);
    check(readyRt === 1'b1, "R8", "ready after reset release", int'(readyRt), 1);
  endtask

  task automatic testFixedMode();
    int hi, lo;
    setCfg(32, 8, 2, 2, 0, 128);
    measure(1, hi, lo);
    check(hi == 52, "R2", "fixed-mode high window", hi, 52);
    check(lo == 28, "R2", "fixed-mode low window", lo, 28);
    check(outFix() == packCfg(64, 16, 6, 5, 1), "R2", "fixed-mode captured values",
          outFix(), packCfg(64, 16, 6, 5, 1));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog R1..all: actual %0d cycles expected fewer", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    testReset();
    testDefaults();
    testLargerMax();
    testSingleCarrier();
    testZeroLow();
    testMidSymbolChange();
    testArmedWait();
    testConfigGate();
    testResetMidSymbol();
    testFixedMode();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule